// File: doc/BRIEF.md
# Pulse-Synchronized Energy Register Latch

This block keeps three per-phase energy accumulators for active energy and three for apparent energy. Each accumulator grows by its increment whenever its accumulate strobe is high. It also watches a one-cycle strobe that marks each high-to-low transition of a pulse converter output. Once a programmed number of these transitions has been counted, the block takes a snapshot of the three accumulators of the kind that drives the pulse train. The snapshot goes into holding registers that can be read. In the same clock cycle it clears those three accumulators.

Because of this, the energy seen in the holding registers lines up with a whole number of output pulses. The source-select code picks the accumulator kind. All three phases are always captured together, even when some phase is left out of the pulse sum. The other accumulator kind is left alone and keeps counting. An enable input gates the whole mechanism.

Top module: `esync_top`

## Requirements
- R1: After reset, all six holding registers and all six internal accumulators are zero.
- R2: In each cycle where an accumulate strobe is high, the matching accumulator grows by its unsigned increment, wrapping modulo 2^ACC_W. The accumulated value appears in the holding register at the next latch.
- R3: With the enable high, a latch fires on the falling-edge strobe that brings the number of counted edges up to the programmed cycle count. Every edge before that one only counts. The captured values show on the holding outputs one clock after the strobe.
- R4: Source code 3'b000 latches the three active accumulators, and code 3'b010 latches the three apparent accumulators. Every other code latches nothing, although edges are still counted. All three phases of the selected kind are always captured together.
- R5: In a latch cycle, each selected accumulator restarts from zero. When its accumulate strobe is high in that same cycle, it restarts from that cycle's increment instead, so no energy is lost.
- R6: The accumulators of the kind that is not selected keep accumulating and are never cleared by a latch.
- R7: While the enable is low, no latch occurs and the edge counter is held at zero.
- R8: A programmed cycle count of 0 behaves as a count of 1, so every enabled edge latches.
- R9: A cycle where the cycle-count input differs from the previous cycle's value clears the edge counter, and any edge in that cycle is not counted. The value recorded at reset is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fall_stb | input | 1 | One-cycle strobe per falling edge of the pulse output |
| latch_en | input | 1 | Enables edge counting and latching |
| src_sel | input | 3 | Pulse source code: 000 active, 010 apparent |
| cyc_cnt | input | 8 | Falling edges between latches (0 acts as 1) |
| act_stb | input | NPH | Accumulate strobes, active energy, one per phase |
| act_inc | input | NPH*INC_W | Active energy increments, phase 0 in the low bits |
| app_stb | input | NPH | Accumulate strobes, apparent energy |
| app_inc | input | NPH*INC_W | Apparent energy increments, phase 0 in the low bits |
| hold_act | output | NPH*ACC_W | Latched active energy per phase |
| hold_app | output | NPH*ACC_W | Latched apparent energy per phase |

## Verification
The bench targets five corner cases.

- A strobe that lands in the latch cycle: a design that clears after adding would drop that increment.
- A count of zero: a naive compare would never fire or would wrap the counter.
- A count rewritten midway through an interval: a design without a restart would latch early, on the old count.
- A reserved source code: a design that decodes it as active power would latch the active registers.
- The unselected kind: holding values would show missing energy if a latch wrongly cleared that kind.

A disabled interval is also covered, where a design that keeps counting would latch as soon as it is re-enabled.

// File: rtl/esync_pkg.sv
package esync_pkg;
    localparam logic [2:0] SRC_ACT = 3'b000;
    localparam logic [2:0] SRC_APP = 3'b010;
    localparam int CYC_W = 8;

    typedef struct packed {
        logic [CYC_W-1:0] cnt;
        logic [CYC_W-1:0] cyc_seen;
    } edge_state_t;
endpackage

// File: rtl/esync_edge_cnt.sv
module esync_edge_cnt
    import esync_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fall_stb,
    input  logic             latch_en,
    input  logic [CYC_W-1:0] cyc_cnt,
    output logic             fire
);
    edge_state_t st_d, st_q;
    logic [CYC_W-1:0] eff;
    logic [CYC_W:0]   nxt;

    always_comb begin
        st_d          = st_q;
        fire          = 1'b0;
        eff           = (cyc_cnt == '0) ? CYC_W'(1) : cyc_cnt;
        nxt           = {1'b0, st_q.cnt} + 1'b1;
        st_d.cyc_seen = cyc_cnt;
        if (cyc_cnt != st_q.cyc_seen) begin
            st_d.cnt = '0;
        end else if (!latch_en) begin
            st_d.cnt = '0;
        end else if (fall_stb) begin
            if (nxt >= {1'b0, eff}) begin
                fire     = 1'b1;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = nxt[CYC_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/esync_bank.sv
module esync_bank #(
    parameter int NPH   = 3,
    parameter int ACC_W = 32,
    parameter int INC_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 snap,
    input  logic [NPH-1:0]       stb,
    input  logic [NPH*INC_W-1:0] inc,
    output logic [NPH*ACC_W-1:0] hold
);
    localparam int EXT_W = ACC_W - INC_W;

    typedef struct packed {
        logic [NPH-1:0][ACC_W-1:0] acc;
        logic [NPH-1:0][ACC_W-1:0] hold;
    } bank_state_t;

    bank_state_t st_d, st_q;
    logic [NPH-1:0][ACC_W-1:0] add;

    for (genvar p = 0; p < NPH; p++) begin : g_ph
        assign add[p] = stb[p] ? {{EXT_W{1'b0}}, inc[p*INC_W +: INC_W]} : '0;
        assign hold[p*ACC_W +: ACC_W] = st_q.hold[p];
    end

    always_comb begin
        st_d = st_q;
        for (int p = 0; p < NPH; p++) begin
            if (snap) begin
                st_d.hold[p] = st_q.acc[p];
                st_d.acc[p]  = add[p];
            end else begin
                st_d.acc[p]  = st_q.acc[p] + add[p];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/esync_top.sv
module esync_top
    import esync_pkg::*;
#(
    parameter int NPH   = 3,
    parameter int ACC_W = 32,
    parameter int INC_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fall_stb,
    input  logic                 latch_en,
    input  logic [2:0]           src_sel,
    input  logic [7:0]           cyc_cnt,
    input  logic [NPH-1:0]       act_stb,
    input  logic [NPH*INC_W-1:0] act_inc,
    input  logic [NPH-1:0]       app_stb,
    input  logic [NPH*INC_W-1:0] app_inc,
    output logic [NPH*ACC_W-1:0] hold_act,
    output logic [NPH*ACC_W-1:0] hold_app
);
    logic fire;
    logic snap_act, snap_app;

    esync_edge_cnt u_cnt (
        .clk(clk), .rst_n(rst_n), .fall_stb(fall_stb),
        .latch_en(latch_en), .cyc_cnt(cyc_cnt), .fire(fire)
    );

    assign snap_act = fire && (src_sel == SRC_ACT);
    assign snap_app = fire && (src_sel == SRC_APP);

    esync_bank #(.NPH(NPH), .ACC_W(ACC_W), .INC_W(INC_W)) u_act (
        .clk(clk), .rst_n(rst_n), .snap(snap_act),
        .stb(act_stb), .inc(act_inc), .hold(hold_act)
    );

    esync_bank #(.NPH(NPH), .ACC_W(ACC_W), .INC_W(INC_W)) u_app (
        .clk(clk), .rst_n(rst_n), .snap(snap_app),
        .stb(app_stb), .inc(app_inc), .hold(hold_app)
    );
endmodule

// File: rtl/esync_chk.sv
module esync_chk #(
    parameter int NPH   = 3,
    parameter int ACC_W = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 fall_stb,
    input logic                 latch_en,
    input logic [2:0]           src_sel,
    input logic [7:0]           cyc_cnt,
    input logic                 fire,
    input logic [NPH*ACC_W-1:0] hold_act,
    input logic [NPH*ACC_W-1:0] hold_app
);
    a_r7_no_latch_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_en |-> !fire);

    a_r3_latch_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> fall_stb);

    a_r4_act_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !(fire && src_sel == 3'b000) |=> $stable(hold_act));

    a_r6_app_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !(fire && src_sel == 3'b010) |=> $stable(hold_app));

    a_r8_zero_every_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_cnt == 8'd0 && $stable(cyc_cnt) && latch_en && fall_stb) |-> fire);

    a_r9_change_no_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_cnt != $past(cyc_cnt)) |-> !fire);
endmodule

bind esync_top esync_chk #(.NPH(NPH), .ACC_W(ACC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .fall_stb(fall_stb), .latch_en(latch_en),
    .src_sel(src_sel), .cyc_cnt(cyc_cnt), .fire(fire),
    .hold_act(hold_act), .hold_app(hold_app)
);

// File: tb/tb_esync_top.sv
module tb_esync_top;
    localparam int NPH = 3, ACC_W = 32, INC_W = 16;

    logic clk = 1'b0, rst_n = 1'b0;
    logic fall_stb = 1'b0, latch_en = 1'b0;
    logic [2:0] src_sel = 3'b000;
    logic [7:0] cyc_cnt = 8'd0;
    logic [NPH-1:0] act_stb = '0, app_stb = '0;
    logic [NPH*INC_W-1:0] act_inc = '0, app_inc = '0;
    logic [NPH*ACC_W-1:0] hold_act, hold_app;

    int total = 0, bad = 0;

    // model state
    logic [ACC_W-1:0] m_aa [NPH], m_pa [NPH], m_ha [NPH], m_hp [NPH];
    logic [7:0] m_cnt = 0, m_prev = 0;
    logic m_fire;

    always #10 clk = ~clk;

    esync_top #(.NPH(NPH), .ACC_W(ACC_W), .INC_W(INC_W)) dut (.*);

    typedef struct packed {
        logic       fall;
        logic       en;
        logic [2:0] sel;
        logic [7:0] cyc;
        logic [2:0] astb;
        logic [2:0] pstb;
        logic       exp_fire;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{1'b0,1'b1,3'd0,8'd2,3'b111,3'b111,1'b0},
        '{1'b1,1'b1,3'd0,8'd2,3'b101,3'b010,1'b0},
        '{1'b0,1'b1,3'd0,8'd2,3'b111,3'b111,1'b0},
        '{1'b1,1'b1,3'd0,8'd2,3'b011,3'b111,1'b1},
        '{1'b0,1'b1,3'd0,8'd2,3'b110,3'b001,1'b0},
        '{1'b1,1'b1,3'd0,8'd2,3'b111,3'b100,1'b0},
        '{1'b1,1'b1,3'd0,8'd2,3'b000,3'b111,1'b1},
        '{1'b0,1'b1,3'd2,8'd2,3'b111,3'b111,1'b0},
        '{1'b1,1'b1,3'd2,8'd2,3'b010,3'b101,1'b0},
        '{1'b1,1'b1,3'd2,8'd2,3'b111,3'b111,1'b1},
        '{1'b1,1'b1,3'd2,8'd3,3'b111,3'b111,1'b0},
        '{1'b1,1'b1,3'd2,8'd3,3'b001,3'b110,1'b0},
        '{1'b1,1'b1,3'd2,8'd3,3'b111,3'b011,1'b0},
        '{1'b1,1'b1,3'd2,8'd3,3'b100,3'b111,1'b1}
    };

    task automatic chk(input bit ok, input string tag, input logic [ACC_W-1:0] act,
                       input logic [ACC_W-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cmp_all(input string tag);
        for (int p = 0; p < NPH; p++) begin
            chk(hold_act[p*ACC_W +: ACC_W] == m_ha[p], tag, hold_act[p*ACC_W +: ACC_W], m_ha[p]);
            chk(hold_app[p*ACC_W +: ACC_W] == m_hp[p], tag, hold_app[p*ACC_W +: ACC_W], m_hp[p]);
        end
    endtask

    task automatic step(input logic fall, input logic en, input logic [2:0] sel,
                        input logic [7:0] cyc, input logic [2:0] astb,
                        input logic [2:0] pstb, input int seed);
        logic [INC_W-1:0] ai, pi;
        logic [7:0] eff;
        @(negedge clk);
        fall_stb = fall; latch_en = en; src_sel = sel; cyc_cnt = cyc;
        act_stb = astb; app_stb = pstb;
        for (int p = 0; p < NPH; p++) begin
            act_inc[p*INC_W +: INC_W] = INC_W'((seed*7 + p*3 + 1) & 16'hff);
            app_inc[p*INC_W +: INC_W] = INC_W'((seed*5 + p*11 + 2) & 16'hff);
        end
        // model per requirements
        m_fire = 1'b0;
        eff = (cyc == 0) ? 8'd1 : cyc;
        if (cyc != m_prev)  m_cnt = 0;          // R9
        else if (!en)       m_cnt = 0;          // R7
        else if (fall) begin
            if (m_cnt + 1 >= eff) begin m_fire = 1'b1; m_cnt = 0; end  // R3, R8
            else m_cnt = m_cnt + 1;
        end
        m_prev = cyc;
        for (int p = 0; p < NPH; p++) begin
            ai = act_inc[p*INC_W +: INC_W];
            pi = app_inc[p*INC_W +: INC_W];
            if (m_fire && sel == 3'b000) begin   // R4, R5
                m_ha[p] = m_aa[p];
                m_aa[p] = astb[p] ? ACC_W'(ai) : '0;
            end else m_aa[p] = m_aa[p] + (astb[p] ? ACC_W'(ai) : '0);  // R2, R6
            if (m_fire && sel == 3'b010) begin
                m_hp[p] = m_pa[p];
                m_pa[p] = pstb[p] ? ACC_W'(pi) : '0;
            end else m_pa[p] = m_pa[p] + (pstb[p] ? ACC_W'(pi) : '0);
        end
        @(posedge clk);
        #2;
    endtask

    task automatic idle(input logic [2:0] sel, input logic [7:0] cyc, input logic en);
        step(1'b0, en, sel, cyc, 3'b000, 3'b000, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [ACC_W-1:0] snap_a;
        for (int p = 0; p < NPH; p++) begin
            m_aa[p] = 0; m_pa[p] = 0; m_ha[p] = 0; m_hp[p] = 0;
        end
        repeat (3) @(posedge clk);
        #2;
        chk(hold_act == '0, "R1 reset act", hold_act[ACC_W-1:0], '0);
        chk(hold_app == '0, "R1 reset app", hold_app[ACC_W-1:0], '0);
        @(negedge clk); rst_n = 1'b1;

        // vector table: R2, R3, R4, R5, R6, R9
        for (int i = 0; i < NV; i++) begin
            step(VEC[i].fall, VEC[i].en, VEC[i].sel, VEC[i].cyc,
                 VEC[i].astb, VEC[i].pstb, i + 1);
            chk(m_fire == VEC[i].exp_fire, "R3 table latch point", 32'(m_fire), 32'(VEC[i].exp_fire));
            cmp_all("R3 table holds");
        end

        // R8: count 0 latches on every edge
        idle(3'b000, 8'd0, 1'b1);
        step(1'b1, 1'b1, 3'b000, 8'd0, 3'b111, 3'b000, 40);
        cmp_all("R8 zero count first edge");
        step(1'b1, 1'b1, 3'b000, 8'd0, 3'b000, 3'b000, 41);
        cmp_all("R8 zero count second edge");
        chk(hold_act[ACC_W-1:0] == 32'((40*7+1) & 8'hff), "R5 strobe in latch cycle kept",
            hold_act[ACC_W-1:0], 32'((40*7+1) & 8'hff));

        // R7: disabled edges never latch, counter held
        idle(3'b000, 8'd2, 1'b0);
        step(1'b1, 1'b0, 3'b000, 8'd2, 3'b111, 3'b000, 50);
        step(1'b1, 1'b0, 3'b000, 8'd2, 3'b111, 3'b000, 51);
        snap_a = hold_act[ACC_W-1:0];
        cmp_all("R7 disabled no latch");
        step(1'b1, 1'b1, 3'b000, 8'd2, 3'b000, 3'b000, 52);
        chk(hold_act[ACC_W-1:0] == snap_a, "R7 counter held at zero", hold_act[ACC_W-1:0], snap_a);
        step(1'b1, 1'b1, 3'b000, 8'd2, 3'b000, 3'b000, 53);
        cmp_all("R7 latch after re-enable");

        // R9: changing the count mid interval restarts
        step(1'b1, 1'b1, 3'b000, 8'd2, 3'b111, 3'b000, 60);
        step(1'b1, 1'b1, 3'b000, 8'd3, 3'b111, 3'b000, 61);
        step(1'b1, 1'b1, 3'b000, 8'd3, 3'b000, 3'b000, 62);
        step(1'b1, 1'b1, 3'b000, 8'd3, 3'b000, 3'b000, 63);
        cmp_all("R9 no early latch after change");
        step(1'b1, 1'b1, 3'b000, 8'd3, 3'b000, 3'b000, 64);
        cmp_all("R9 latch after new count");

        // R4: reserved code latches nothing
        snap_a = hold_act[ACC_W-1:0];
        step(1'b1, 1'b1, 3'b011, 8'd1, 3'b111, 3'b111, 70);
        step(1'b1, 1'b1, 3'b011, 8'd1, 3'b111, 3'b111, 71);
        chk(hold_act[ACC_W-1:0] == snap_a, "R4 reserved code act", hold_act[ACC_W-1:0], snap_a);
        cmp_all("R4 reserved code");

        // R6: apparent latch leaves active accumulating
        step(1'b1, 1'b1, 3'b010, 8'd1, 3'b111, 3'b111, 80);
        step(1'b1, 1'b1, 3'b000, 8'd1, 3'b000, 3'b000, 81);
        cmp_all("R6 unselected kept accumulating");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule